// File: doc/BRIEF.md
# PHY Test-Port Write Sequencer

This block turns a single write request, made of an 8-bit test code and an 8-bit test value, into the ordered edge sequence that a PHY configuration test port expects. The port has a test clock, a test enable, one shared 8-bit data-in bus, an 8-bit data-out bus and a test clear. Code and value travel on the same bus. The PHY tells them apart only by the enable level and by the direction of the clock edge. A falling clock edge with the enable high latches the code. A rising clock edge with the enable low then commits the value into the register that the latched code selects.

Requests arrive on a valid/ready interface. Each write runs through five phases: PRE, SETUP, FALL, SWAP and RISE. Every phase is held for a programmable number of system clocks, so the port's setup and hold times can be met at any system clock rate. A separate clear request pulses the test clear for one phase, and only while the sequencer is idle. The state machine has seven states: IDLE, the five write phases, and CLEAR. Its transitions are:
- IDLE→CLEAR on a clear request.
- IDLE→PRE when a request is accepted.
- Each write phase moves to the next one when its hold count expires.
- RISE→IDLE, and CLEAR→IDLE, when the hold count expires.

Top module: `phy_tp_seq`

## Requirements
- R1: After reset the port is at rest and the interface is ready to accept a request. At rest, test clock = 1, enable = 0, data-in = 0x00 and clear = 0. The interface shows ready = 1 and busy = 0.
- R2: An accepted write drives five phases in this fixed order, as (clock, enable, data-in):
  - PRE = (1, 0, 0x00)
  - SETUP = (1, 1, code)
  - FALL = (0, 1, code)
  - SWAP = (0, 0, value)
  - RISE = (1, 0, value)
  
  The port then returns to rest.
- R3: Each phase lasts H system clocks, where H is the hold input sampled on the acceptance cycle. A hold value of 0 is treated as 1. A whole write therefore takes 5·H cycles.
- R4: Ready is low and busy is high from the cycle after acceptance through the last cycle of RISE. Ready returns high on the following cycle.
- R5: The test clock falls only while the enable is high and the code is on the bus. It rises only while the enable is low. Data-in does not change in a cycle where the clock changes. A port model therefore stores the value under the code.
- R6: Data-out is driven as 0x00 at all times.
- R7: A clear request while idle drives clear = 1, clock = 1, enable = 0 and data-in = 0x00 for H cycles. Busy is high and ready is low during that time, and the port then returns to rest.
- R8: A clear request made while a write is in progress is ignored. It does not pulse the clear, either during that write or after it.
- R9: If a clear request and a valid write request arrive in the same idle cycle, the clear wins. Ready is low in that cycle, and the write is accepted only after the clear phase ends.
- R10: Changing the hold input during a write does not alter the phase lengths of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_hold | input | HOLD_W | System clocks per phase (0 means 1) |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Write request may be accepted this cycle |
| req_code | input | DATA_W | Test code of the request |
| req_value | input | DATA_W | Test value of the request |
| clr_req | input | 1 | Request a test-clear pulse |
| busy | output | 1 | Sequencer is not idle |
| tp_clk | output | 1 | Port test clock |
| tp_en | output | 1 | Port test enable |
| tp_din | output | DATA_W | Port shared code/value bus |
| tp_dout | output | DATA_W | Port data-out field, always zero |
| tp_clr | output | 1 | Port test clear |

## Verification
Two functions can fall in the same cycle: a clear request and a write request arriving together while idle, and a clear request landing in the middle of a running write. The bench provokes the first by raising both in one idle cycle. It judges that ready is low in that cycle, that a full clear phase runs with no clock edge on the port, and that the write only lands in the port model's register file after the clear has finished. It provokes the second by pulsing the clear request one cycle into a write while also changing the hold input. It judges that the write's waveform and phase lengths match the unchanged expectation and that the clear-pulse count of the model stays the same.

// File: rtl/phy_tp_pkg.sv
package phy_tp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_SETUP = 3'd2,
        ST_FALL  = 3'd3,
        ST_SWAP  = 3'd4,
        ST_RISE  = 3'd5,
        ST_CLEAR = 3'd6
    } tp_state_e;

endpackage

// File: rtl/phy_tp_timer.sv
module phy_tp_timer #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_len,
    output logic              done
);

    logic [HOLD_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_len - HOLD_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - HOLD_W'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/phy_tp_capture.sv
module phy_tp_capture #(
    parameter int DATA_W = 8,
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] code_i,
    input  logic [DATA_W-1:0] value_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic [DATA_W-1:0] code_q,
    output logic [DATA_W-1:0] value_q,
    output logic [HOLD_W-1:0] hold_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            value_q <= '0;
            hold_q  <= HOLD_W'(1);
        end else if (take) begin
            code_q  <= code_i;
            value_q <= value_i;
            hold_q  <= hold_i;
        end
    end

endmodule

// File: rtl/phy_tp_fsm.sv
module phy_tp_fsm
    import phy_tp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              clr_req,
    input  logic              phase_done,
    input  logic [DATA_W-1:0] code_q,
    input  logic [DATA_W-1:0] value_q,
    output logic              is_idle,
    output logic              accept,
    output logic              phase_load,
    output logic              req_ready,
    output logic              busy,
    output logic              tp_clk,
    output logic              tp_en,
    output logic [DATA_W-1:0] tp_din,
    output logic              tp_clr
);

    tp_state_e state_q;
    tp_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clr_req) begin
                    state_d = ST_CLEAR;
                end else if (req_valid) begin
                    state_d = ST_PRE;
                end
            end
            ST_PRE:   if (phase_done) state_d = ST_SETUP;
            ST_SETUP: if (phase_done) state_d = ST_FALL;
            ST_FALL:  if (phase_done) state_d = ST_SWAP;
            ST_SWAP:  if (phase_done) state_d = ST_RISE;
            ST_RISE:  if (phase_done) state_d = ST_IDLE;
            ST_CLEAR: if (phase_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign is_idle    = (state_q == ST_IDLE);
    assign req_ready  = is_idle && !clr_req;
    assign accept     = req_ready && req_valid;
    assign phase_load = (state_d != state_q);
    assign busy       = !is_idle;

    // port outputs
    always_comb begin
        tp_clk = 1'b1;
        tp_en  = 1'b0;
        tp_din = '0;
        tp_clr = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PRE: begin
                tp_clk = 1'b1;
            end
            ST_SETUP: begin
                tp_en  = 1'b1;
                tp_din = code_q;
            end
            ST_FALL: begin
                tp_clk = 1'b0;
                tp_en  = 1'b1;
                tp_din = code_q;
            end
            ST_SWAP: begin
                tp_clk = 1'b0;
                tp_din = value_q;
            end
            ST_RISE: begin
                tp_din = value_q;
            end
            ST_CLEAR: begin
                tp_clr = 1'b1;
            end
            default: begin
                tp_clk = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/phy_tp_seq.sv
module phy_tp_seq #(
    parameter int DATA_W = 8,
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_code,
    input  logic [DATA_W-1:0] req_value,
    input  logic              clr_req,
    output logic              busy,
    output logic              tp_clk,
    output logic              tp_en,
    output logic [DATA_W-1:0] tp_din,
    output logic [DATA_W-1:0] tp_dout,
    output logic              tp_clr
);

    logic [HOLD_W-1:0] hold_in;
    logic [HOLD_W-1:0] hold_q;
    logic [HOLD_W-1:0] load_len;
    logic [DATA_W-1:0] code_q;
    logic [DATA_W-1:0] value_q;
    logic              is_idle;
    logic              accept;
    logic              phase_load;
    logic              phase_done;

    assign hold_in  = (cfg_hold == '0) ? HOLD_W'(1) : cfg_hold;
    assign load_len = is_idle ? hold_in : hold_q;
    assign tp_dout  = '0;

    phy_tp_capture #(
        .DATA_W (DATA_W),
        .HOLD_W (HOLD_W)
    ) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (accept),
        .code_i  (req_code),
        .value_i (req_value),
        .hold_i  (hold_in),
        .code_q  (code_q),
        .value_q (value_q),
        .hold_q  (hold_q)
    );

    phy_tp_timer #(
        .HOLD_W (HOLD_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_len (load_len),
        .done     (phase_done)
    );

    phy_tp_fsm #(
        .DATA_W (DATA_W)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .clr_req    (clr_req),
        .phase_done (phase_done),
        .code_q     (code_q),
        .value_q    (value_q),
        .is_idle    (is_idle),
        .accept     (accept),
        .phase_load (phase_load),
        .req_ready  (req_ready),
        .busy       (busy),
        .tp_clk     (tp_clk),
        .tp_en      (tp_en),
        .tp_din     (tp_din),
        .tp_clr     (tp_clr)
    );

endmodule

// File: rtl/phy_tp_chk.sv
module phy_tp_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              clr_req,
    input logic              busy,
    input logic              tp_clk,
    input logic              tp_en,
    input logic [DATA_W-1:0] tp_din,
    input logic [DATA_W-1:0] tp_dout,
    input logic              tp_clr
);

    assert_fall_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tp_clk) |-> tp_en);

    assert_rise_noen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tp_clk) |-> !tp_en);

    assert_din_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tp_clk) || $rose(tp_clk)) |-> $stable(tp_din));

    assert_dout_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tp_dout == '0);

    assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));

    assert_ready_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !busy);

    assert_clr_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tp_clr |-> (tp_clk && !tp_en && busy));

    assert_clr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tp_clr) |=> !tp_clr);

    assert_clr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !busy) |=> tp_clr);

endmodule

bind phy_tp_seq phy_tp_chk #(.DATA_W(DATA_W)) i_phy_tp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .clr_req   (clr_req),
    .busy      (busy),
    .tp_clk    (tp_clk),
    .tp_en     (tp_en),
    .tp_din    (tp_din),
    .tp_dout   (tp_dout),
    .tp_clr    (tp_clr)
);

// File: tb/test_phy_tp_seq.sv
`timescale 1ns/1ps
module test_phy_tp_seq;

    localparam int DW = 8;
    localparam int HW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] cfg_hold = HW'(1);
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [DW-1:0] req_code = '0;
    logic [DW-1:0] req_value = '0;
    logic          clr_req = 1'b0;
    logic          busy;
    logic          tp_clk;
    logic          tp_en;
    logic [DW-1:0] tp_din;
    logic [DW-1:0] tp_dout;
    logic          tp_clr;

    always #2.5 clk = ~clk;

    phy_tp_seq #(.DATA_W(DW), .HOLD_W(HW)) i_phy_tp_seq (
        .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_code(req_code), .req_value(req_value),
        .clr_req(clr_req), .busy(busy),
        .tp_clk(tp_clk), .tp_en(tp_en), .tp_din(tp_din),
        .tp_dout(tp_dout), .tp_clr(tp_clr)
    );

    // port model: falling edge with enable latches code, rising edge without enable writes
    logic [DW-1:0] mdl_code;
    logic [DW-1:0] mdl_reg [0:255];
    int            clr_seen = 0;

    always @(negedge tp_clk) if (rst_n && tp_en) mdl_code <= tp_din;
    always @(posedge tp_clk) if (rst_n && !tp_en) mdl_reg[mdl_code] <= tp_din;
    always @(posedge tp_clr) if (rst_n) clr_seen++;

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // {clk, en, din, clr, busy, ready}
    function automatic logic [12:0] act_vec();
        return {tp_clk, tp_en, tp_din, tp_clr, busy, req_ready};
    endfunction

    function automatic logic [12:0] idle_vec();
        return {1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1};
    endfunction

    function automatic logic [12:0] clear_vec();
        return {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0};
    endfunction

    function automatic logic [12:0] phase_vec(input int ph, input logic [7:0] c, input logic [7:0] v);
        case (ph)
            0:       return {1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0};
            1:       return {1'b1, 1'b1, c,     1'b0, 1'b1, 1'b0};
            2:       return {1'b0, 1'b1, c,     1'b0, 1'b1, 1'b0};
            3:       return {1'b0, 1'b0, v,     1'b0, 1'b1, 1'b0};
            default: return {1'b1, 1'b0, v,     1'b0, 1'b1, 1'b0};
        endcase
    endfunction

    task automatic run_txn(input logic [7:0] c, input logic [7:0] v,
                           input int h, input bit disturb);
        int heff;
        int clr_before;
        heff = (h == 0) ? 1 : h;
        clr_before = clr_seen;
        @(negedge clk);
        req_code  = c;
        req_value = v;
        cfg_hold  = HW'(h);
        req_valid = 1'b1;
        #1 chk("R4 ready before accept", {31'd0, req_ready}, 32'd1);
        @(posedge clk);
        for (int i = 0; i < 5 * heff; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_code  = $urandom;
            req_value = $urandom;
            if (disturb && i == 1) begin
                clr_req  = 1'b1;
                cfg_hold = HW'($urandom_range(1, 15));
            end else begin
                clr_req = 1'b0;
            end
            #1;
            if (disturb)
                chk("R10 R8 R2 R3 R4 phase under disturbance", {19'd0, act_vec()},
                    {19'd0, phase_vec(i / heff, c, v)});
            else
                chk("R2 R3 R4 phase waveform", {19'd0, act_vec()},
                    {19'd0, phase_vec(i / heff, c, v)});
        end
        @(negedge clk);
        clr_req = 1'b0;
        #1;
        chk("R4 back to idle after RISE", {19'd0, act_vec()}, {19'd0, idle_vec()});
        chk("R5 model register written", {24'd0, mdl_reg[c]}, {24'd0, v});
        chk("R6 data-out zero", {24'd0, tp_dout}, 32'd0);
        if (disturb)
            chk("R8 no clear pulse during write", clr_before, clr_seen);
    endtask

    task automatic run_clear(input int h, input bit with_req,
                             input logic [7:0] c, input logic [7:0] v);
        int heff;
        int clr_before;
        heff = (h == 0) ? 1 : h;
        clr_before = clr_seen;
        @(negedge clk);
        cfg_hold = HW'(h);
        clr_req  = 1'b1;
        if (with_req) begin
            req_valid = 1'b1;
            req_code  = c;
            req_value = v;
        end
        #1 chk("R9 ready low while clear requested", {31'd0, req_ready}, 32'd0);
        @(posedge clk);
        for (int i = 0; i < heff; i++) begin
            @(negedge clk);
            clr_req = 1'b0;
            #1 chk(with_req ? "R9 R7 clear phase before write" : "R7 clear phase",
                   {19'd0, act_vec()}, {19'd0, clear_vec()});
        end
        chk("R7 one clear pulse seen", clr_seen, clr_before + 1);
        if (with_req) begin
            run_txn(c, v, h, 1'b0);
        end else begin
            @(negedge clk);
            #1 chk("R7 rest after clear", {19'd0, act_vec()}, {19'd0, idle_vec()});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset state", {19'd0, act_vec()}, {19'd0, idle_vec()});
        chk("R6 data-out after reset", {24'd0, tp_dout}, 32'd0);

        // directed corners
        run_txn(8'h10, 8'hA5, 1, 1'b0);
        run_txn(8'h00, 8'hFF, 3, 1'b0);
        run_txn(8'hFF, 8'h00, 0, 1'b0);   // R3 hold 0 treated as 1
        run_txn(8'h7E, 8'h81, 15, 1'b0);
        run_clear(2, 1'b0, 8'h00, 8'h00);
        run_clear(1, 1'b1, 8'h3C, 8'hC3);
        run_txn(8'h44, 8'h5A, 2, 1'b1);
        run_txn(8'h45, 8'h99, 1, 1'b1);

        // random mix
        for (int k = 0; k < 40; k++) begin
            logic [7:0] c;
            logic [7:0] v;
            int h;
            c = 8'($urandom);
            v = 8'($urandom);
            h = int'($urandom_range(0, 4));
            if (k % 8 == 3)
                run_clear(h, (k % 16) == 3, c, v);
            else
                run_txn(c, v, h, (k % 5) == 2);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule